// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the system-control exception sequencer of a 32-bit pipelined core that has branch delay slots. When the pipeline reports a trap, it records where execution must restart. That is the trapping PC, or the PC of the preceding branch when the trap hits a delay-slot instruction. It also records why the trap happened, raises the exception or error level, and produces the handler address. On a return-from-exception strobe it lowers the correct level and gives back the saved restart address. Both kinds of event produce a one-cycle redirect that the fetch stage follows.

Handler addresses are built from a base and an offset. The base is a fixed boot region while the bootstrap-vector bit is set. Otherwise the base comes from a programmable register. The offset depends on the trap class, on the dedicated-interrupt-vector bit and on whether the core is already at exception level. Reset-class events and cache errors take a separate error-level path with fixed or uncached targets.

Software updates the status bits, the interrupt-vector bit and the base through plain write strobes. Writes are dropped in any cycle in which a trap or return takes effect.

Top module: `trap_sequencer`

## Requirements
- R1: After reset: redirectValid is 0, statusBev is 1, statusExl and statusErl are 0, vecBase is 0x8000_0000, and epc and errorEpc are 0.
- R2: A general-path trap taken while statusExl is 0 does the following. It sets epc to curPc and causeBd to 0, or to curPc-4 and causeBd to 1 when inDelaySlot is 1. It loads causeCe from copNum and causeExcCode from excCode. It sets statusExl. The general path is excClass 0 (general), 1 (interrupt), 2 (TLB refill) and the unused codes 5 to 7.
- R3: A general-path trap taken while statusExl is 1 leaves epc and causeBd unchanged. It still loads the cause fields, and it uses offset 0x180 whatever the class.
- R4: With statusExl at 0, the handler offset is 0x000 for TLB refill and 0x200 for an interrupt while causeIv is 1. Every other general-path case uses 0x180.
- R5: The general base is 0xBFC0_0200 while statusBev is 1, and vecBase while statusBev is 0.
- R6: A base write (baseWe, baseWdata = address bits 31:12) takes effect only while statusBev is 1. vecBase bits 11:0 always read 0.
- R7: A reset-class trap (excClass 4) redirects to 0xBFC0_0000. It sets statusErl and saves the restart address (same delay-slot rule as R2) in errorEpc. epc, causeBd and statusExl are left unchanged.
- R8: A cache-error trap (excClass 3) takes the error-level path of R7. It redirects to 0xBFC0_0300 while statusBev is 1. While statusBev is 0 it redirects to {vecBase[31:30], 1, vecBase[28:12], 12'h000}.
- R9: eretReq with statusErl set clears only statusErl and redirects to errorEpc. statusExl is kept.
- R10: eretReq with statusErl clear and statusExl set clears statusExl and redirects to epc.
- R11: eretReq with both levels clear changes nothing and produces no redirect.
- R12: When excReq and eretReq coincide, the trap is taken and the return is ignored. Status, cause and base writes (statusWe with newBev/newErl/newExl, causeWe with newIv) are dropped in any cycle in which a trap or return takes effect.
- R13: Each trap or effective return raises redirectValid for exactly one cycle, starting at the clock edge that samples the request, with redirectPc valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Trap request from the pipeline |
| excClass | input | 3 | Trap class: 0 general, 1 interrupt, 2 TLB refill, 3 cache error, 4 reset-class |
| excCode | input | 5 | Cause code recorded in causeExcCode |
| inDelaySlot | input | 1 | Trapping instruction sits in a branch delay slot |
| curPc | input | 32 | PC of the trapping instruction |
| copNum | input | 2 | Faulting coprocessor number |
| eretReq | input | 1 | Return-from-exception strobe |
| statusWe | input | 1 | Software write of the status bits |
| newBev | input | 1 | Written bootstrap-vector bit |
| newErl | input | 1 | Written error-level bit |
| newExl | input | 1 | Written exception-level bit |
| causeWe | input | 1 | Software write of the interrupt-vector bit |
| newIv | input | 1 | Written interrupt-vector bit |
| baseWe | input | 1 | Software write of the handler base |
| baseWdata | input | 20 | Base address bits 31:12 |
| redirectValid | output | 1 | One-cycle redirect strobe |
| redirectPc | output | 32 | Handler or return address |
| epc | output | 32 | Exception restart address |
| errorEpc | output | 32 | Error-level restart address |
| statusBev | output | 1 | Bootstrap-vector bit |
| statusExl | output | 1 | Exception level |
| statusErl | output | 1 | Error level |
| causeBd | output | 1 | Last captured trap was in a delay slot |
| causeIv | output | 1 | Dedicated interrupt vector enable |
| causeCe | output | 2 | Faulting coprocessor number |
| causeExcCode | output | 5 | Recorded cause code |
| vecBase | output | 32 | Programmable handler base |

## Verification
The bench targets the nested trap. A design that recaptured the restart address at exception level would lose the first handler's return point, and one that honoured the refill offset there would jump to the wrong handler. It checks the delay-slot restart, where a wrong subtraction resumes past the branch. It checks return precedence with both levels set, where clearing the exception level first, or both levels, would skip the outer handler. It also covers the cache-error uncached address bit, base writes while the programmable base is live, and trap/return collisions, where a design that honoured the return would lose the trap.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    CLS_GENERAL   = 3'd0,
    CLS_INTERRUPT = 3'd1,
    CLS_REFILL    = 3'd2,
    CLS_CACHEERR  = 3'd3,
    CLS_RESET     = 3'd4
  } trapClass_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BOOT,
    TGT_CACHE,
    TGT_OFF000,
    TGT_OFF180,
    TGT_OFF200,
    TGT_EPC,
    TGT_ERREPC
  } target_e;

  typedef struct packed {
    logic    fire;
    logic    saveEpc;
    logic    saveErrEpc;
    logic    loadCause;
    logic    setExl;
    logic    clrExl;
    logic    setErl;
    logic    clrErl;
    logic    swWrite;
    target_e target;
  } seqCtl_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic       excReq,
  input  logic [2:0] excClass,
  input  logic       eretReq,
  input  logic       exlNow,
  input  logic       erlNow,
  input  logic       ivNow,
  output seqCtl_t    ctl
);

  trapClass_e cls;
  assign cls = trapClass_e'(excClass);

  always_comb begin
    ctl = '0;
    ctl.target = TGT_NONE;
    if (excReq) begin
      ctl.fire = 1'b1;
      case (cls)
        CLS_RESET: begin
          ctl.saveErrEpc = 1'b1;
          ctl.setErl     = 1'b1;
          ctl.target     = TGT_BOOT;
        end
        CLS_CACHEERR: begin
          ctl.saveErrEpc = 1'b1;
          ctl.setErl     = 1'b1;
          ctl.target     = TGT_CACHE;
        end
        default: begin
          ctl.saveEpc   = !exlNow;
          ctl.loadCause = 1'b1;
          ctl.setExl    = 1'b1;
          if (exlNow)                          ctl.target = TGT_OFF180;
          else if (cls == CLS_REFILL)          ctl.target = TGT_OFF000;
          else if (cls == CLS_INTERRUPT && ivNow) ctl.target = TGT_OFF200;
          else                                 ctl.target = TGT_OFF180;
        end
      endcase
    end else if (eretReq) begin
      if (erlNow) begin
        ctl.fire   = 1'b1;
        ctl.clrErl = 1'b1;
        ctl.target = TGT_ERREPC;
      end else if (exlNow) begin
        ctl.fire   = 1'b1;
        ctl.clrExl = 1'b1;
        ctl.target = TGT_EPC;
      end
    end
    ctl.swWrite = !ctl.fire;
  end

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          CODE_W     = 5,
  parameter int          COP_W      = 2,
  parameter int          PAGE_BITS  = 12,
  parameter logic [31:0] BOOT_VEC   = 32'hBFC0_0000,
  parameter logic [31:0] BEV_BASE   = 32'hBFC0_0200,
  parameter logic [31:0] CACHE_BOOT = 32'hBFC0_0300,
  parameter logic [31:0] BASE_RESET = 32'h8000_0000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqCtl_t                     ctl,
  input  logic [CODE_W-1:0]           excCode,
  input  logic                        inDelaySlot,
  input  logic [ADDR_W-1:0]           curPc,
  input  logic [COP_W-1:0]            copNum,
  input  logic                        statusWe,
  input  logic                        newBev,
  input  logic                        newErl,
  input  logic                        newExl,
  input  logic                        causeWe,
  input  logic                        newIv,
  input  logic                        baseWe,
  input  logic [ADDR_W-PAGE_BITS-1:0] baseWdata,
  output logic                        redirectValid,
  output logic [ADDR_W-1:0]           redirectPc,
  output logic [ADDR_W-1:0]           epc,
  output logic [ADDR_W-1:0]           errorEpc,
  output logic                        bev,
  output logic                        exl,
  output logic                        erl,
  output logic                        bd,
  output logic                        iv,
  output logic [COP_W-1:0]            ce,
  output logic [CODE_W-1:0]           code,
  output logic [ADDR_W-1:0]           vecBase
);

  localparam int HI_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_GEN    = ADDR_W'(12'h180);
  localparam logic [ADDR_W-1:0] OFF_INT    = ADDR_W'(12'h200);

  logic [HI_W-1:0]   baseHi;
  logic [ADDR_W-1:0] restartPc, genBase, uncachedBase, targetPc;

  assign vecBase      = {baseHi, {PAGE_BITS{1'b0}}};
  assign restartPc    = inDelaySlot ? curPc - INSN_BYTES : curPc;
  assign genBase      = bev ? BEV_BASE[ADDR_W-1:0] : vecBase;
  assign uncachedBase = {vecBase[ADDR_W-1 -: 2], 1'b1, vecBase[ADDR_W-4:PAGE_BITS],
                         {PAGE_BITS{1'b0}}};

  always_comb begin
    case (ctl.target)
      TGT_BOOT:   targetPc = BOOT_VEC[ADDR_W-1:0];
      TGT_CACHE:  targetPc = bev ? CACHE_BOOT[ADDR_W-1:0] : uncachedBase;
      TGT_OFF000: targetPc = genBase;
      TGT_OFF180: targetPc = genBase + OFF_GEN;
      TGT_OFF200: targetPc = genBase + OFF_INT;
      TGT_EPC:    targetPc = epc;
      TGT_ERREPC: targetPc = errorEpc;
      default:    targetPc = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      epc           <= '0;
      errorEpc      <= '0;
      bev           <= 1'b1;
      exl           <= 1'b0;
      erl           <= 1'b0;
      bd            <= 1'b0;
      iv            <= 1'b0;
      ce            <= '0;
      code          <= '0;
      baseHi        <= BASE_RESET[ADDR_W-1:PAGE_BITS];
    end else begin
      redirectValid <= ctl.fire;
      if (ctl.fire) redirectPc <= targetPc;
      if (ctl.saveEpc) begin
        epc <= restartPc;
        bd  <= inDelaySlot;
      end
      if (ctl.saveErrEpc) errorEpc <= restartPc;
      if (ctl.loadCause) begin
        ce   <= copNum;
        code <= excCode;
      end
      if (ctl.setExl) exl <= 1'b1;
      if (ctl.clrExl) exl <= 1'b0;
      if (ctl.setErl) erl <= 1'b1;
      if (ctl.clrErl) erl <= 1'b0;
      if (ctl.swWrite) begin
        if (statusWe) begin
          bev <= newBev;
          erl <= newErl;
          exl <= newExl;
        end
        if (causeWe) iv <= newIv;
        if (baseWe && bev) baseHi <= baseWdata;
      end
    end
  end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          CODE_W    = 5,
  parameter int          COP_W     = 2,
  parameter int          PAGE_BITS = 12,
  parameter logic [31:0] BOOT_VEC  = 32'hBFC0_0000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        excReq,
  input  logic [2:0]                  excClass,
  input  logic [CODE_W-1:0]           excCode,
  input  logic                        inDelaySlot,
  input  logic [ADDR_W-1:0]           curPc,
  input  logic [COP_W-1:0]            copNum,
  input  logic                        eretReq,
  input  logic                        statusWe,
  input  logic                        newBev,
  input  logic                        newErl,
  input  logic                        newExl,
  input  logic                        causeWe,
  input  logic                        newIv,
  input  logic                        baseWe,
  input  logic [ADDR_W-PAGE_BITS-1:0] baseWdata,
  output logic                        redirectValid,
  output logic [ADDR_W-1:0]           redirectPc,
  output logic [ADDR_W-1:0]           epc,
  output logic [ADDR_W-1:0]           errorEpc,
  output logic                        statusBev,
  output logic                        statusExl,
  output logic                        statusErl,
  output logic                        causeBd,
  output logic                        causeIv,
  output logic [COP_W-1:0]            causeCe,
  output logic [CODE_W-1:0]           causeExcCode,
  output logic [ADDR_W-1:0]           vecBase
);

  seqCtl_t ctl;

  trap_ctrl u_ctrl (
    .excReq   (excReq),
    .excClass (excClass),
    .eretReq  (eretReq),
    .exlNow   (statusExl),
    .erlNow   (statusErl),
    .ivNow    (causeIv),
    .ctl      (ctl)
  );

  trap_dp #(
    .ADDR_W    (ADDR_W),
    .CODE_W    (CODE_W),
    .COP_W     (COP_W),
    .PAGE_BITS (PAGE_BITS),
    .BOOT_VEC  (BOOT_VEC)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .excCode       (excCode),
    .inDelaySlot   (inDelaySlot),
    .curPc         (curPc),
    .copNum        (copNum),
    .statusWe      (statusWe),
    .newBev        (newBev),
    .newErl        (newErl),
    .newExl        (newExl),
    .causeWe       (causeWe),
    .newIv         (newIv),
    .baseWe        (baseWe),
    .baseWdata     (baseWdata),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .epc           (epc),
    .errorEpc      (errorEpc),
    .bev           (statusBev),
    .exl           (statusExl),
    .erl           (statusErl),
    .bd            (causeBd),
    .iv            (causeIv),
    .ce            (causeCe),
    .code          (causeExcCode),
    .vecBase       (vecBase)
  );

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              excReq,
  input logic [2:0]        excClass,
  input logic              eretReq,
  input logic              inDelaySlot,
  input logic [ADDR_W-1:0] curPc,
  input logic              baseWe,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] redirectPc,
  input logic [ADDR_W-1:0] epc,
  input logic [ADDR_W-1:0] errorEpc,
  input logic              statusBev,
  input logic              statusExl,
  input logic              statusErl,
  input logic              causeBd,
  input logic [ADDR_W-1:0] vecBase
);

  logic generalCls;
  assign generalCls = (excClass != 3'd3) && (excClass != 3'd4);

  // R2
  epc_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq && generalCls && !statusExl && inDelaySlot
      |=> epc == $past(curPc) - ADDR_W'(4) && causeBd && statusExl);

  // R3
  nested_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq && generalCls && statusExl
      |=> epc == $past(epc) && causeBd == $past(causeBd));

  // R6
  base_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWe && !statusBev |=> vecBase == $past(vecBase));

  // R7
  boot_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq && excClass == 3'd4
      |=> redirectValid && redirectPc == BOOT_VEC[ADDR_W-1:0] && statusErl);

  // R9
  eret_erl_chk: assert property (@(posedge clk) disable iff (!rstN)
    eretReq && !excReq && statusErl
      |=> !statusErl && statusExl == $past(statusExl)
          && redirectPc == $past(errorEpc));

  // R12
  collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq && eretReq && generalCls |=> statusExl && redirectValid);

  // R13
  pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !excReq && !eretReq |=> !redirectValid);

endmodule

bind trap_sequencer trap_sequencer_chk #(.ADDR_W(ADDR_W), .BOOT_VEC(BOOT_VEC)) u_chk (.*);

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [2:0]  excClass = '0;
  logic [4:0]  excCode = '0;
  logic        inDelaySlot = 1'b0;
  logic [31:0] curPc = '0;
  logic [1:0]  copNum = '0;
  logic        eretReq = 1'b0;
  logic        statusWe = 1'b0, newBev = 1'b0, newErl = 1'b0, newExl = 1'b0;
  logic        causeWe = 1'b0, newIv = 1'b0;
  logic        baseWe = 1'b0;
  logic [19:0] baseWdata = '0;
  logic        redirectValid;
  logic [31:0] redirectPc, epc, errorEpc, vecBase;
  logic        statusBev, statusExl, statusErl, causeBd, causeIv;
  logic [1:0]  causeCe;
  logic [4:0]  causeExcCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  trap_sequencer u_dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Drive one request for one cycle; return at the negedge after the sampling edge.
  task automatic trap(input logic [2:0] cls, input logic [4:0] cd, input logic [31:0] pc,
                      input logic ds, input logic [1:0] cop);
    @(negedge clk);
    excReq = 1'b1; excClass = cls; excCode = cd; curPc = pc; inDelaySlot = ds; copNum = cop;
    @(negedge clk);
    excReq = 1'b0; inDelaySlot = 1'b0;
  endtask

  task automatic eret();
    @(negedge clk);
    eretReq = 1'b1;
    @(negedge clk);
    eretReq = 1'b0;
  endtask

  task automatic idleCheck(input string req);
    @(negedge clk);
    check(req, {31'd0, redirectValid}, 32'd0);
  endtask

  task automatic writeStatus(input logic b);
    @(negedge clk);
    statusWe = 1'b1; newBev = b; newErl = 1'b0; newExl = 1'b0;
    @(negedge clk);
    statusWe = 1'b0;
  endtask

  task automatic tReset();
    check("R1 redirectValid", {31'd0, redirectValid}, 32'd0);
    check("R1 bev", {31'd0, statusBev}, 32'd1);
    check("R1 exl/erl", {30'd0, statusExl, statusErl}, 32'd0);
    check("R1 vecBase", vecBase, 32'h8000_0000);
    check("R1 epc", epc, 32'd0);
    check("R1 errorEpc", errorEpc, 32'd0);
  endtask

  task automatic tFirstAndNested();
    trap(3'd0, 5'd5, 32'h1000, 1'b0, 2'd1);
    check("R13 valid", {31'd0, redirectValid}, 32'd1);
    check("R4 R5 general vector", redirectPc, 32'hBFC0_0380);
    check("R2 epc", epc, 32'h1000);
    check("R2 bd", {31'd0, causeBd}, 32'd0);
    check("R2 exl", {31'd0, statusExl}, 32'd1);
    check("R2 code", {27'd0, causeExcCode}, 32'd5);
    check("R2 ce", {30'd0, causeCe}, 32'd1);
    idleCheck("R13 single pulse");
    trap(3'd0, 5'd4, 32'h2000, 1'b1, 2'd0);
    check("R3 epc kept", epc, 32'h1000);
    check("R3 bd kept", {31'd0, causeBd}, 32'd0);
    check("R3 code loaded", {27'd0, causeExcCode}, 32'd4);
    check("R3 vector", redirectPc, 32'hBFC0_0380);
    trap(3'd2, 5'd2, 32'h2100, 1'b0, 2'd0);
    check("R3 refill at exl", redirectPc, 32'hBFC0_0380);
    eret();
    check("R10 return pc", redirectPc, 32'h1000);
    check("R10 exl cleared", {31'd0, statusExl}, 32'd0);
  endtask

  task automatic tDelaySlotAndOffsets();
    trap(3'd2, 5'd3, 32'h3000, 1'b1, 2'd0);
    check("R4 refill vector", redirectPc, 32'hBFC0_0200);
    check("R2 delay-slot epc", epc, 32'h0000_2FFC);
    check("R2 delay-slot bd", {31'd0, causeBd}, 32'd1);
    eret();
    check("R10 delay-slot return", redirectPc, 32'h0000_2FFC);
    trap(3'd1, 5'd0, 32'h3100, 1'b0, 2'd0);
    check("R4 interrupt iv=0", redirectPc, 32'hBFC0_0380);
    eret();
    @(negedge clk); causeWe = 1'b1; newIv = 1'b1;
    @(negedge clk); causeWe = 1'b0;
    trap(3'd1, 5'd0, 32'h3200, 1'b0, 2'd0);
    check("R4 interrupt iv=1", redirectPc, 32'hBFC0_0400);
    eret();
  endtask

  task automatic tBase();
    @(negedge clk); baseWe = 1'b1; baseWdata = 20'h90000;
    @(negedge clk); baseWe = 1'b0;
    check("R6 base write bev=1", vecBase, 32'h9000_0000);
    writeStatus(1'b0);
    check("R5 bev cleared", {31'd0, statusBev}, 32'd0);
    @(negedge clk); baseWe = 1'b1; baseWdata = 20'h12345;
    @(negedge clk); baseWe = 1'b0;
    check("R6 base write ignored", vecBase, 32'h9000_0000);
    trap(3'd0, 5'd8, 32'h3300, 1'b0, 2'd0);
    check("R5 programmable base", redirectPc, 32'h9000_0180);
    eret();
  endtask

  task automatic tErrorLevel();
    trap(3'd3, 5'd0, 32'h4000, 1'b0, 2'd0);
    check("R8 uncached vector", redirectPc, 32'hB000_0000);
    check("R8 erl", {31'd0, statusErl}, 32'd1);
    check("R8 errorEpc", errorEpc, 32'h4000);
    check("R8 exl untouched", {31'd0, statusExl}, 32'd0);
    trap(3'd0, 5'd9, 32'h5000, 1'b0, 2'd0);
    check("R2 epc under erl", epc, 32'h5000);
    eret();
    check("R9 return errorEpc", redirectPc, 32'h4000);
    check("R9 erl cleared", {31'd0, statusErl}, 32'd0);
    check("R9 exl kept", {31'd0, statusExl}, 32'd1);
    eret();
    check("R10 then epc", redirectPc, 32'h5000);
    writeStatus(1'b1);
    trap(3'd3, 5'd0, 32'h4100, 1'b0, 2'd0);
    check("R8 boot cache vector", redirectPc, 32'hBFC0_0300);
    eret();
    trap(3'd4, 5'd0, 32'h6000, 1'b1, 2'd0);
    check("R7 boot vector", redirectPc, 32'hBFC0_0000);
    check("R7 errorEpc", errorEpc, 32'h0000_5FFC);
    check("R7 epc untouched", epc, 32'h5000);
    check("R7 exl untouched", {31'd0, statusExl}, 32'd0);
    eret();
    check("R9 reset-class return", redirectPc, 32'h0000_5FFC);
  endtask

  task automatic tCollisions();
    @(negedge clk);
    excReq = 1'b1; eretReq = 1'b1; excClass = 3'd0; excCode = 5'd1; curPc = 32'h7000;
    statusWe = 1'b1; newBev = 1'b0; newErl = 1'b0; newExl = 1'b0;
    @(negedge clk);
    excReq = 1'b0; eretReq = 1'b0; statusWe = 1'b0;
    check("R12 trap wins", redirectPc, 32'hBFC0_0380);
    check("R12 exl set", {31'd0, statusExl}, 32'd1);
    check("R12 epc", epc, 32'h7000);
    check("R12 write dropped", {31'd0, statusBev}, 32'd1);
    eret();
    check("R10 after collision", redirectPc, 32'h7000);
    eret();
    check("R11 no redirect", {31'd0, redirectValid}, 32'd0);
    check("R11 levels clear", {30'd0, statusExl, statusErl}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFirstAndNested();
    tDelaySlotAndOffsets();
    tBase();
    tErrorLevel();
    tCollisions();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule